// File: doc/BRIEF.md
# Bit Count Unit

This block returns one of three bit statistics of a 64-bit operand: the number of zero bits above the most significant one bit, the number of zero bits below the least significant one bit, or the total number of one bits. Each statistic has a full-width form and a word form. The word form uses only the low 32 bits of the operand and ignores the upper half completely.

A request is an operand and an operation code, qualified by `in_valid`. The count appears one clock later on `result`, zero-extended to 64 bits, and `out_valid` is high in that cycle. An all-zero operand has a defined count: the leading and trailing counts give the width that was examined (64 or 32).

When no request is presented, `result` keeps its last value. This lets a consumer read a count late without having to capture it.

Top module: `bitcnt_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to 0 after that edge, whatever the other inputs are.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: Op code 0 returns the number of zero bits from bit 63 downward before the first one bit.
- R4: Op code 1 returns the number of zero bits from bit 31 downward before the first one bit. Bits 63..32 do not affect the result.
- R5: Op code 2 returns the number of zero bits from bit 0 upward before the first one bit.
- R6: Op code 3 returns the same count as op code 2, but examines only bits 31..0. Bits 63..32 do not affect the result.
- R7: Op code 4 returns the number of one bits in all 64 bits.
- R8: Op code 5 returns the number of one bits in bits 31..0 only.
- R9: A zero operand gives 64 for op codes 0 and 2, 32 for op codes 1 and 3, and 0 for op codes 4 and 5. An operand that is zero only in its low 32 bits gives 32 for op codes 1 and 3.
- R10: `result[63:7]` is always zero.
- R11: Op codes 6 and 7 return 0, with `out_valid` set as usual.
- R12: In the cycle after a cycle with `in_valid` low, `result` equals its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request qualifier |
| op | input | 3 | Operation code (0..5 valid, 6/7 return 0) |
| a | input | 64 | Operand |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Zero-extended count |

## Verification
The delivery of the previous result and the acceptance of a new request happen in the same cycle. The bench issues requests back to back, and changes the op code and operand on every clock. This way each registered count must match the request of the preceding cycle and not the one now on the inputs. The bench also inserts idle cycles between requests. In those cycles it checks that the held result stays equal to the last count while `out_valid` drops. A reference model compares every cycle.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;
    typedef enum logic [2:0] {
        OP_LZ   = 3'd0,
        OP_LZW  = 3'd1,
        OP_TZ   = 3'd2,
        OP_TZW  = 3'd3,
        OP_POP  = 3'd4,
        OP_POPW = 3'd5
    } cnt_op_e;
endpackage

// File: rtl/bitcnt_lead_zero.sv
module bitcnt_lead_zero #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Ascending scan: the last one bit seen is the highest, so it decides the count.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/bitcnt_popcnt.sv
module bitcnt_popcnt #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit
    import bitcnt_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    output logic          out_valid,
    output logic [DW-1:0] result
);
    localparam int HW  = DW / 2;
    localparam int CWF = $clog2(DW + 1);
    localparam int CWH = $clog2(HW + 1);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } state_t;

    state_t state_d, state_q;

    // Bit-reversed operand: trailing counts reuse the leading-zero scanner.
    logic [DW-1:0] a_rev;
    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign a_rev[i] = a[DW-1-i];
    end

    logic [CWF-1:0] lz_full, tz_full, pc_full;
    logic [CWH-1:0] lz_word, tz_word, pc_word;

    bitcnt_lead_zero #(.W(DW), .CW(CWF)) u_lz_full (.vec(a),                 .cnt(lz_full));
    bitcnt_lead_zero #(.W(HW), .CW(CWH)) u_lz_word (.vec(a[HW-1:0]),         .cnt(lz_word));
    bitcnt_lead_zero #(.W(DW), .CW(CWF)) u_tz_full (.vec(a_rev),             .cnt(tz_full));
    bitcnt_lead_zero #(.W(HW), .CW(CWH)) u_tz_word (.vec(a_rev[DW-1:HW]),    .cnt(tz_word));
    bitcnt_popcnt    #(.W(DW), .CW(CWF)) u_pc_full (.vec(a),                 .cnt(pc_full));
    bitcnt_popcnt    #(.W(HW), .CW(CWH)) u_pc_word (.vec(a[HW-1:0]),         .cnt(pc_word));

    logic [CWF-1:0] cnt_sel;

    always_comb begin
        case (cnt_op_e'(op))
            OP_LZ:   cnt_sel = lz_full;
            OP_LZW:  cnt_sel = CWF'(lz_word);
            OP_TZ:   cnt_sel = tz_full;
            OP_TZW:  cnt_sel = CWF'(tz_word);
            OP_POP:  cnt_sel = pc_full;
            OP_POPW: cnt_sel = CWF'(pc_word);
            default: cnt_sel = '0;
        endcase

        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = {{(DW-CWF){1'b0}}, cnt_sel};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
endmodule

// File: rtl/bitcnt_unit_chk.sv
module bitcnt_unit_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [2:0]    op,
    input logic [DW-1:0] a,
    input logic          out_valid,
    input logic [DW-1:0] result
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        result[DW-1:7] == '0); // R10
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R12
    AST_POP_FULL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4) |=> result == DW'($countones($past(a)))); // R7
    AST_WORD_LZ_BOUND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd1) |=> result <= DW'(32)); // R4
    AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b11) |=> result == '0); // R11
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0)); // R1
endmodule

bind bitcnt_unit bitcnt_unit_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a),
    .out_valid(out_valid), .result(result)
);

// File: tb/tb_bitcnt_unit.sv
`timescale 1ns/1ps
module tb_bitcnt_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [63:0] a;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic        exp_v;
    logic [63:0] exp_r;

    always #5 clk = ~clk;

    bitcnt_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a),
        .out_valid(out_valid), .result(result)
    );

    function automatic int lead(logic [63:0] x, int n);
        int c = 0;
        for (int i = n - 1; i >= 0; i--) begin
            if (x[i]) return c;
            c++;
        end
        return c;
    endfunction

    function automatic int trail(logic [63:0] x, int n);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            if (x[i]) return c;
            c++;
        end
        return c;
    endfunction

    function automatic logic [63:0] model(logic [2:0] o, logic [63:0] x);
        case (o)
            3'd0: return 64'(lead(x, 64));
            3'd1: return 64'(lead(x, 32));
            3'd2: return 64'(trail(x, 64));
            3'd3: return 64'(trail(x, 32));
            3'd4: return 64'($countones(x));
            3'd5: return 64'($countones(x[31:0]));
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] o, logic [63:0] x);
        if (x == 64'd0 || (o inside {3'd1, 3'd3} && x[31:0] == 32'd0)) return "R9";
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic r, logic v, logic [2:0] o, logic [63:0] x);
        string t;
        @(negedge clk);
        rst = r; in_valid = v; op = o; a = x;
        @(posedge clk);
        if (r) begin
            exp_v = 1'b0; exp_r = 64'd0; t = "R1";
        end else begin
            exp_v = v;
            if (v) begin
                exp_r = model(o, x); t = tag_of(o, x);
            end else begin
                t = "R12";
            end
        end
        #2;
        chk(r ? "R1" : "R2", {63'd0, out_valid}, {63'd0, exp_v});
        chk(t, result, exp_r);
        chk("R10", {7'd0, result[63:7]}, 64'd0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 3'd0; a = '0;
        exp_v = 1'b0; exp_r = '0;
        // R1: reset wins over a live request
        step(1, 1, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        step(1, 1, 3'd0, 64'd1);
        // R9: zero operand for all ops
        for (int o = 0; o < 8; o++) step(0, 1, 3'(o), 64'd0);
        // R4/R6/R9: upper half only, word forms must see zero
        for (int o = 0; o < 6; o++) step(0, 1, 3'(o), 64'hFFFF_FFFF_0000_0000);
        // Corners per op
        for (int o = 0; o < 8; o++) begin
            step(0, 1, 3'(o), 64'hFFFF_FFFF_FFFF_FFFF);
            step(0, 1, 3'(o), 64'd1);
            step(0, 1, 3'(o), 64'h8000_0000_0000_0000);
            step(0, 1, 3'(o), 64'h0000_0000_8000_0000);
            step(0, 1, 3'(o), 64'h0000_0001_0000_0000);
        end
        // R12: idle gap holds last count
        step(0, 1, 3'd4, 64'h0F0F_0000_0000_00F0);
        step(0, 0, 3'd0, 64'd0);
        step(0, 0, 3'd2, 64'hFFFF);
        // Back-to-back random with occasional idles
        for (int k = 0; k < 400; k++) begin
            logic [63:0] x;
            x = {$urandom, $urandom};
            if (k % 3 == 1) x = x & (x << (k % 40));
            step(0, (k % 7) != 3, 3'($urandom % 8), x);
        end
        // R1: reset mid-stream
        step(1, 1, 3'd0, 64'd5);
        step(0, 0, 3'd0, 64'd5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule